// File: doc/BRIEF.md
# Four-Channel Performance Event Counter Bank

This block watches a wide vector of single-bit event signals from the surrounding chip. The signals are grouped into islands of equal size. Four independent 32-bit counters each pick one signal from that vector. Each counter runs in one of two modes. In cycle mode it counts the clocks for which its signal is high. In pulse mode it counts occurrences, so a level that stays high is counted only once, on its rising edge. A global run bit starts and stops all four counters together. To keep the routing of monitored signals bounded, the four selections may together touch at most two islands. A selector write that would bring in a third island is refused, and the selector keeps its old value.

An optional sampling timer fires once every N enabled cycles, where N is programmable. When it fires, all four counts are copied into snapshot registers along with a running sample number. On that same edge the live counters restart from zero, so each event lands in exactly one sample period. Counters saturate at all ones instead of wrapping, and each counter has a sticky overflow flag.

Configuration and readout use a plain register port: a write strobe with address and data, and a read strobe whose data returns one cycle later together with a valid flag. There is no stream traffic, so no valid/ready handshake is used. Reads and writes are always accepted and never stall.

Top module: `perf_event_bank`

## Requirements
- R1: After reset, every readable register reads zero: control, interval, selectors, live counts, snapshots, sample number and overflow status.
- R2: In cycle mode (selector bit 8 = 0) a counter adds one on each clock edge where the run bit (control bit 0) is 1 and its selected event is high.
- R3: In pulse mode (selector bit 8 = 1) a counter adds one only on an edge where its selected event is high and was low on the previous edge, so a held level counts once.
- R4: A selector write (address 2+k for counter k, event index in bits 4:0, island = index / 8) is ignored when the four resulting selections would span more than two distinct islands; an accepted write takes effect at the next edge.
- R5: While the run bit is 0, live counts do not change except by register write, and the sampling timer does not advance.
- R6: A counter at all ones stays at all ones on further events and sets its overflow flag (status register 15, bit k). The flag stays set until a 1 is written to that bit.
- R7: With run and sampling (control bit 1) both set, on every N-th enabled edge (N = register 1, with 0 treated as 1) each snapshot register (10+k) takes the count including that edge's event. Each live counter is cleared on the same edge, and register 14 takes the sample number, which starts at 0.
- R8: Read data for address A appears on rd_data with rd_valid high exactly one cycle after rd_en. A write to address 6+k loads counter k directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt | input | 32 | Monitored event vector, island i holds bits 8i to 8i+7 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| rd_valid | output | 1 | High in the cycle rd_data is valid |

## Verification
A register write lands on the next clock edge. An event level present at an edge counts on that same edge. Read data is registered and appears one cycle after the strobe, and a snapshot is taken on the N-th enabled edge after the run bits are set. The bench drives inputs on falling edges and samples on falling edges. It clears the run bit on the same edge that the last stimulus is consumed, and only then reads, so each result it checks is frozen. The expected snapshot values, residual counts and sample numbers come from counting the enabled edges between the two control writes.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int unsigned PM_NCTR = 4;
  localparam int unsigned PM_AW   = 4;

  localparam logic [PM_AW-1:0] A_CTRL  = 4'd0;
  localparam logic [PM_AW-1:0] A_IVAL  = 4'd1;
  localparam logic [PM_AW-1:0] A_SEL0  = 4'd2;
  localparam logic [PM_AW-1:0] A_CNT0  = 4'd6;
  localparam logic [PM_AW-1:0] A_SNAP0 = 4'd10;
  localparam logic [PM_AW-1:0] A_SIDX  = 4'd14;
  localparam logic [PM_AW-1:0] A_STAT  = 4'd15;

  localparam int unsigned CTL_RUN_BIT  = 0;
  localparam int unsigned CTL_SMP_BIT  = 1;
  localparam int unsigned SEL_MODE_BIT = 8;

  typedef enum logic {
    CM_CYCLE = 1'b0,
    CM_PULSE = 1'b1
  } cmode_e;
endpackage

// File: rtl/pmon_event_tap.sv
module pmon_event_tap import pmon_pkg::*; #(
  parameter int unsigned NEVT   = 32,
  parameter int unsigned EIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEVT-1:0]   evt,
  input  logic [EIDX_W-1:0] sel,
  input  cmode_e            mode,
  input  logic              run,
  output logic              inc
);
  logic cur;
  logic prev_q;

  assign cur = evt[sel];

  // previous level of the selected line, tracked every cycle
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  always_comb begin
    if (mode == CM_PULSE) inc = run & cur & ~prev_q;
    else                  inc = run & cur;
  end
endmodule

// File: rtl/pmon_sat_counter.sv
module pmon_sat_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clr,
  input  logic         ovf_clr,
  output logic [W-1:0] cnt,
  output logic [W-1:0] nxt,
  output logic         ovf
);
  logic at_top;

  assign at_top = (cnt == {W{1'b1}});
  assign nxt    = (inc && !at_top) ? cnt + 1'b1 : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (clr)  cnt <= '0;
    else           cnt <= nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       ovf <= 1'b0;
    else if (inc && at_top && !load)  ovf <= 1'b1;
    else if (ovf_clr)                 ovf <= 1'b0;
  end
endmodule

// File: rtl/pmon_island_guard.sv
module pmon_island_guard #(
  parameter int unsigned NCTR        = 4,
  parameter int unsigned EIDX_W      = 5,
  parameter int unsigned EVT_PER_ISL = 8,
  parameter int unsigned MAX_ISL     = 2
) (
  input  logic [NCTR-1:0][EIDX_W-1:0] cur_sel,
  input  logic [NCTR-1:0]             wr_hit,
  input  logic [EIDX_W-1:0]           new_evt,
  output logic                        accept
);
  int isl  [NCTR];
  int ndist;

  always_comb begin
    for (int i = 0; i < int'(NCTR); i++) begin
      if (wr_hit[i]) isl[i] = int'(new_evt) / int'(EVT_PER_ISL);
      else           isl[i] = int'(cur_sel[i]) / int'(EVT_PER_ISL);
    end
    ndist = 0;
    for (int i = 0; i < int'(NCTR); i++) begin
      logic first;
      first = 1'b1;
      for (int j = 0; j < i; j++) begin
        if (isl[j] == isl[i]) first = 1'b0;
      end
      if (first) ndist = ndist + 1;
    end
    accept = (ndist <= int'(MAX_ISL));
  end
endmodule

// File: rtl/pmon_sample_timer.sv
module pmon_sample_timer #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] interval,
  output logic         fire
);
  logic [W-1:0] tmr_q;

  // an interval of 0 behaves like 1: fire on every enabled edge
  assign fire = run && (({1'b0, tmr_q} + 1'b1) >= {1'b0, interval});

  always_ff @(posedge clk) begin
    if (!rst_n)     tmr_q <= '0;
    else if (!run)  tmr_q <= '0;
    else if (fire)  tmr_q <= '0;
    else            tmr_q <= tmr_q + 1'b1;
  end
endmodule

// File: rtl/perf_event_bank.sv
module perf_event_bank import pmon_pkg::*; #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned NUM_ISL     = 4,
  parameter int unsigned EVT_PER_ISL = 8,
  parameter int unsigned MAX_ISL     = 2,
  localparam int unsigned NEVT       = NUM_ISL * EVT_PER_ISL,
  localparam int unsigned EIDX_W     = (NEVT > 1) ? $clog2(NEVT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEVT-1:0]   evt,
  input  logic              wr_en,
  input  logic [PM_AW-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [PM_AW-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int unsigned NCTR = PM_NCTR;

  logic                          ctl_run;
  logic                          ctl_smp;
  logic [DATA_W-1:0]             ival_q;
  logic [NCTR-1:0][EIDX_W-1:0]   sel_q;
  logic [NCTR-1:0]               mode_q;
  logic [NCTR-1:0][DATA_W-1:0]   cnt_q;
  logic [NCTR-1:0][DATA_W-1:0]   cnt_nxt;
  logic [NCTR-1:0][DATA_W-1:0]   snap_q;
  logic [NCTR-1:0]               ovf_q;
  logic [NCTR-1:0]               inc;
  logic [NCTR-1:0]               sel_hit;
  logic [NCTR-1:0]               cnt_hit;
  logic [DATA_W-1:0]             sidx_q;
  logic [DATA_W-1:0]             snap_idx_q;
  logic                          smp_fire;
  logic                          sel_accept;
  logic                          stat_wr;
  logic [DATA_W-1:0]             rd_mux;

  assign stat_wr = wr_en && (wr_addr == A_STAT);

  // control and interval registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_run <= 1'b0;
      ctl_smp <= 1'b0;
      ival_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL) begin
        ctl_run <= wr_data[CTL_RUN_BIT];
        ctl_smp <= wr_data[CTL_SMP_BIT];
      end
      if (wr_addr == A_IVAL) ival_q <= wr_data;
    end
  end

  pmon_island_guard #(
    .NCTR(NCTR), .EIDX_W(EIDX_W), .EVT_PER_ISL(EVT_PER_ISL), .MAX_ISL(MAX_ISL)
  ) u_guard (
    .cur_sel (sel_q),
    .wr_hit  (sel_hit),
    .new_evt (wr_data[EIDX_W-1:0]),
    .accept  (sel_accept)
  );

  pmon_sample_timer #(.W(DATA_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctl_run & ctl_smp),
    .interval (ival_q),
    .fire     (smp_fire)
  );

  for (genvar k = 0; k < NCTR; k++) begin : g_ch
    assign sel_hit[k] = wr_en && (wr_addr == A_SEL0 + 4'(k));
    assign cnt_hit[k] = wr_en && (wr_addr == A_CNT0 + 4'(k));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sel_q[k]  <= '0;
        mode_q[k] <= 1'b0;
      end else if (sel_hit[k] && sel_accept) begin
        sel_q[k]  <= wr_data[EIDX_W-1:0];
        mode_q[k] <= wr_data[SEL_MODE_BIT];
      end
    end

    pmon_event_tap #(.NEVT(NEVT), .EIDX_W(EIDX_W)) u_tap (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt),
      .sel   (sel_q[k]),
      .mode  (cmode_e'(mode_q[k])),
      .run   (ctl_run),
      .inc   (inc[k])
    );

    pmon_sat_counter #(.W(DATA_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (inc[k]),
      .load     (cnt_hit[k]),
      .load_val (wr_data),
      .clr      (smp_fire),
      .ovf_clr  (stat_wr && wr_data[k]),
      .cnt      (cnt_q[k]),
      .nxt      (cnt_nxt[k]),
      .ovf      (ovf_q[k])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)        snap_q[k] <= '0;
      else if (smp_fire) snap_q[k] <= cnt_nxt[k];
    end
  end

  // sample numbering: snapshot carries the number, then it advances
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sidx_q     <= '0;
      snap_idx_q <= '0;
    end else if (smp_fire) begin
      snap_idx_q <= sidx_q;
      sidx_q     <= sidx_q + 1'b1;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr == A_CTRL) begin
      rd_mux[CTL_RUN_BIT] = ctl_run;
      rd_mux[CTL_SMP_BIT] = ctl_smp;
    end
    if (rd_addr == A_IVAL) rd_mux = ival_q;
    if (rd_addr == A_SIDX) rd_mux = snap_idx_q;
    if (rd_addr == A_STAT) rd_mux[NCTR-1:0] = ovf_q;
    for (int k = 0; k < int'(NCTR); k++) begin
      if (rd_addr == A_SEL0 + 4'(k)) begin
        rd_mux[EIDX_W-1:0]   = sel_q[k];
        rd_mux[SEL_MODE_BIT] = mode_q[k];
      end
      if (rd_addr == A_CNT0 + 4'(k))  rd_mux = cnt_q[k];
      if (rd_addr == A_SNAP0 + 4'(k)) rd_mux = snap_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/pmon_bank_chk.sv
module pmon_bank_chk import pmon_pkg::*; #(
  parameter int unsigned NCTR        = 4,
  parameter int unsigned W           = 32,
  parameter int unsigned EIDX_W      = 5,
  parameter int unsigned EVT_PER_ISL = 8,
  parameter int unsigned MAX_ISL     = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [PM_AW-1:0]            wr_addr,
  input logic                        rd_en,
  input logic                        rd_valid,
  input logic                        run,
  input logic                        fire,
  input logic [NCTR-1:0][W-1:0]      cnt,
  input logic [NCTR-1:0]             ovf,
  input logic [NCTR-1:0][EIDX_W-1:0] sel
);
  function automatic int isl_span(input logic [NCTR-1:0][EIDX_W-1:0] s);
    int n;
    n = 0;
    for (int i = 0; i < int'(NCTR); i++) begin
      logic seen;
      seen = 1'b0;
      for (int j = 0; j < i; j++)
        if (int'(s[j]) / int'(EVT_PER_ISL) == int'(s[i]) / int'(EVT_PER_ISL)) seen = 1'b1;
      if (!seen) n = n + 1;
    end
    return n;
  endfunction

  // R4
  isl_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isl_span(sel) <= int'(MAX_ISL));

  // R8
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  for (genvar k = 0; k < NCTR; k++) begin : g_k
    // R5
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_en) |=> $stable(cnt[k]));

    // R6
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[k] == {W{1'b1}} && !wr_en && !fire) |=> cnt[k] == {W{1'b1}});

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf[k] && !(wr_en && wr_addr == A_STAT)) |=> ovf[k]);

    // R7
    snap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !wr_en) |=> cnt[k] == '0);
  end
endmodule

bind perf_event_bank pmon_bank_chk #(
  .NCTR(PM_NCTR), .W(DATA_W), .EIDX_W(EIDX_W),
  .EVT_PER_ISL(EVT_PER_ISL), .MAX_ISL(MAX_ISL)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .run      (ctl_run),
  .fire     (smp_fire),
  .cnt      (cnt_q),
  .ovf      (ovf_q),
  .sel      (sel_q)
);

// File: tb/sim_perf_event_bank.sv
`timescale 1ns/1ps
module sim_perf_event_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_valid;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  perf_event_bank u0 (
    .clk(clk), .rst_n(rst_n), .evt(evt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // {mode, event index, 16-bit pattern driven MSB first, expected count}
  localparam logic [29:0] VEC [9] = '{
    {1'b0, 5'd3,  16'hFFFF, 8'd16},
    {1'b1, 5'd3,  16'hFFFF, 8'd1},
    {1'b0, 5'd12, 16'hAAAA, 8'd8},
    {1'b1, 5'd12, 16'hAAAA, 8'd8},
    {1'b0, 5'd20, 16'h0F0F, 8'd8},
    {1'b1, 5'd20, 16'h0F0F, 8'd2},
    {1'b0, 5'd31, 16'h7FFE, 8'd14},
    {1'b1, 5'd31, 16'h7FFE, 8'd1},
    {1'b1, 5'd7,  16'h8001, 8'd2}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // tasks start and end just after a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
    checks++;
    if (rd_valid !== 1'b1) begin
      errors++;
      $display("FAIL R8 rd_valid got %b expected 1", rd_valid);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, v);  chk("R1 ctrl", v, 32'd0);
    rd(4'd1, v);  chk("R1 interval", v, 32'd0);
    rd(4'd2, v);  chk("R1 sel0", v, 32'd0);
    rd(4'd6, v);  chk("R1 cnt0", v, 32'd0);
    rd(4'd10, v); chk("R1 snap0", v, 32'd0);
    rd(4'd14, v); chk("R1 sample", v, 32'd0);
    rd(4'd15, v); chk("R1 status", v, 32'd0);

    // R2 / R3 vector table on counter 0
    for (int i = 0; i < 9; i++) begin
      wr(4'd2, {23'd0, VEC[i][29], 3'd0, VEC[i][28:24]});
      wr(4'd6, 32'd0);
      wr(4'd0, 32'd1);
      for (int b = 15; b >= 0; b--) begin
        evt[VEC[i][28:24]] = VEC[i][8 + b];
        @(negedge clk);
      end
      evt = '0;
      wr(4'd0, 32'd0);
      rd(4'd6, v);
      chk(VEC[i][29] ? "R3 pulse count" : "R2 cycle count", v, {24'd0, VEC[i][7:0]});
    end

    // R7 sampling, interval 10, all counters on event 0 in cycle mode
    wr(4'd2, 32'd0);
    wr(4'd6, 32'd0);
    evt[0] = 1'b1;
    wr(4'd1, 32'd10);
    wr(4'd0, 32'd3);
    repeat (25) @(negedge clk);
    wr(4'd0, 32'd0);           // 26 enabled edges: fires at 10 and 20
    evt[0] = 1'b0;
    rd(4'd10, v); chk("R7 snap0", v, 32'd10);
    rd(4'd11, v); chk("R7 snap1", v, 32'd10);
    rd(4'd14, v); chk("R7 sample number", v, 32'd1);
    rd(4'd6, v);  chk("R7 residual cnt0", v, 32'd6);

    // R5 run bit low: events ignored
    for (int c = 0; c < 6; c++) begin
      evt[0] = ~evt[0];
      @(negedge clk);
    end
    evt[0] = 1'b0;
    rd(4'd6, v);  chk("R5 cnt0 frozen", v, 32'd6);
    rd(4'd14, v); chk("R5 sample number frozen", v, 32'd1);

    // R6 saturation on counter 1, R8 direct load
    wr(4'd1, 32'd0);
    wr(4'd7, 32'hFFFF_FFFE);
    rd(4'd7, v);  chk("R8 load cnt1", v, 32'hFFFF_FFFE);
    evt[0] = 1'b1;
    wr(4'd0, 32'd1);
    repeat (2) @(negedge clk);
    wr(4'd0, 32'd0);           // 3 enabled edges
    evt[0] = 1'b0;
    rd(4'd7, v);  chk("R6 cnt1 saturated", v, 32'hFFFF_FFFF);
    rd(4'd6, v);  chk("R6 cnt0 plain", v, 32'd9);
    rd(4'd15, v); chk("R6 overflow flag", v, 32'h2);
    wr(4'd15, 32'h1);
    rd(4'd15, v); chk("R6 flag kept", v, 32'h2);
    wr(4'd15, 32'h2);
    rd(4'd15, v); chk("R6 flag cleared", v, 32'h0);

    // R4 island limit (island = index / 8)
    wr(4'd2, 32'd8);
    wr(4'd3, 32'd9);
    wr(4'd4, 32'd16);          // islands 1,1,2,0: refused
    rd(4'd4, v);  chk("R4 third island refused", v, 32'd0);
    wr(4'd5, 32'd10);
    wr(4'd4, 32'd16);          // islands 1,1,2,1: accepted
    rd(4'd4, v);  chk("R4 two islands accepted", v, 32'd16);
    wr(4'd2, 32'h118);         // island 3: refused
    rd(4'd2, v);  chk("R4 sel0 unchanged", v, 32'd8);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule